// File: doc/BRIEF.md
# Triggered Frequency Ramp Sequencer

This block drives the frequency word of a fractional-N synthesizer through stepped ramps. The word is 40 bits wide: a 16-bit integer part in bits 39:24 above a 24-bit fractional part in bits 23:0. While the ramp is disabled, the word follows a programmed base value. Once the ramp is enabled, the block records that value as the start point. From then on it adds or subtracts a programmable step, and each step carries into or borrows from the integer part. Triggers and the reference-rate tick decide when each step is taken.

Four behaviours are selectable. Two-way sweeps go out on one trigger and come back on the next. One-way sweeps always run in the first direction, and every other trigger snaps the word back to the start. Single-step operation moves one step per trigger. Auto-repeat starts on its own and, after a programmed pause, sweeps back and forth until it is disabled.

The trigger comes either from a register strobe or from the rising edge of an asynchronous pin; a select bit picks the source. The word-update strobe is a valid-only stream with no ready. Every new word must be taken by the synthesizer in the cycle it appears, so there is no back-pressure. Busy and the configuration pins are plain levels.

Top module: `fsweep_seq`

## Requirements
- R1: After reset, freq_word is 0 and busy and word_upd are low. While ramp_en is low, freq_word takes base_word one clock later and word_upd stays low.
- R2: Each step adds step_val (zero-extended) to the whole 40-bit word, or subtracts it, modulo 2^40. The fraction therefore carries into, or borrows from, the integer part in bits 39:24. word_upd is high for exactly the one cycle in which a new word first appears, and the word does not change in any other cycle while the ramp is enabled.
- R3: In automatic stepping, a sweep takes one step on each ref_tick and step_num steps in total (a value of 0 is treated as 1). It ends at start ± step_num·step_val.
- R4: With start_down=0 the first sweep after enable rises; with start_down=1 it falls.
- R5: In two-way mode without repeat, the word holds after the last step. The next trigger sweeps in the opposite direction back to the start, and each later sweep reverses again.
- R6: In one-way mode without repeat, the first trigger after a completed sweep sets the word straight back to the start value. That trigger gives one word_upd and does not raise busy. The trigger after it sweeps again in the initial direction.
- R7: With single_step=1, each trigger takes exactly one step and ref_tick has no effect. Busy rises with the first step and falls with the step_num-th. In one-way mode, trigger step_num+1 returns to the start and trigger step_num+2 steps again.
- R8: With auto_repeat=1, the first sweep starts at enable without any trigger. After its last step the block lets dwell_num ref_ticks pass (at least one) and takes the first step of the reverse sweep on the tick after that. This alternation repeats.
- R9: With ext_sel=0, a one-cycle reg_trig is the trigger. With ext_sel=1, only a rising edge of ext_trig, passed through a two-flop synchronizer, is a trigger. The unselected source is ignored.
- R10: In automatic stepping, busy rises on the clock that accepts the trigger and falls with the last step. A trigger that arrives while busy is ignored and does not lengthen the sweep.
- R11: The start point is latched when ramp_en rises, and base_word changes made while the ramp is enabled have no effect. Dropping ramp_en clears busy and returns the word to following base_word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference-domain clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_tick | input | 1 | One-cycle pulse per reference period |
| base_word | input | 40 | Word followed while the ramp is disabled |
| ramp_en | input | 1 | Ramp enable; rising edge latches the start point |
| auto_repeat | input | 1 | Self-starting alternating sweeps with dwell |
| one_way | input | 1 | One-direction sweeps with hop back to start |
| single_step | input | 1 | One step per trigger |
| start_down | input | 1 | First sweep direction (1 = falling) |
| ext_sel | input | 1 | Trigger source select (1 = external pin) |
| step_val | input | 24 | Step added to the fractional part |
| step_num | input | 16 | Steps per sweep |
| dwell_num | input | 16 | Reference ticks of pause between auto sweeps |
| reg_trig | input | 1 | Register-write trigger strobe |
| ext_trig | input | 1 | Asynchronous external trigger pin |
| freq_word | output | 40 | Current frequency word |
| busy | output | 1 | A sweep is in progress |
| word_upd | output | 1 | Valid strobe for a new freq_word |

## Verification
The embedded properties watch the same things on every cycle. The word never changes without word_upd. Every word change while busy is exactly one step in size. An automatic sweep is never cut short. A synchronized external edge lasts one cycle, and busy is low whenever the ramp was disabled. Other behaviours can only be shown by the directed scenarios, because they depend on sequences of triggers: the direction of each sweep, trigger parity in one-way and single-step modes, the hop back to the latched start, the length of the dwell, and whether the unselected trigger source is ignored.

// File: rtl/fsweep_pkg.sv
`timescale 1ns/1ps
package fsweep_pkg;
  typedef enum logic [2:0] {
    SW_OFF   = 3'd0,
    SW_HOLD  = 3'd1,
    SW_RAMP  = 3'd2,
    SW_SSTEP = 3'd3,
    SW_DWELL = 3'd4
  } sw_state_t;
endpackage

// File: rtl/fsweep_trig.sv
`timescale 1ns/1ps
module fsweep_trig (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_sel,
  input  logic reg_trig,
  input  logic ext_trig,
  output logic trig
);
  logic sync1, sync2, prev;
  logic ext_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= 1'b0;
      sync2 <= 1'b0;
      prev  <= 1'b0;
    end else begin
      sync1 <= ext_trig;
      sync2 <= sync1;
      prev  <= sync2;
    end
  end

  assign ext_rise = sync2 & ~prev;
  assign trig     = ext_sel ? ext_rise : reg_trig;

  AST_EXT_EDGE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    ext_rise |=> !ext_rise); // R9
endmodule

// File: rtl/fsweep_step.sv
`timescale 1ns/1ps
module fsweep_step #(
  parameter int WORD_W = 40,
  parameter int STEP_W = 24
) (
  input  logic [WORD_W-1:0] cur,
  input  logic [STEP_W-1:0] step,
  input  logic              down,
  output logic [WORD_W-1:0] nxt
);
  localparam int PAD = WORD_W - STEP_W;
  logic [WORD_W-1:0] wide;

  generate
    if (PAD > 0) begin : g_pad
      assign wide = {{PAD{1'b0}}, step};
    end else begin : g_nopad
      assign wide = step[WORD_W-1:0];
    end
  endgenerate

  assign nxt = down ? (cur - wide) : (cur + wide);
endmodule

// File: rtl/fsweep_ctrl.sv
`timescale 1ns/1ps
module fsweep_ctrl
  import fsweep_pkg::*;
#(
  parameter int WORD_W  = 40,
  parameter int CNT_W   = 16,
  parameter int DWELL_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ref_tick,
  input  logic               trig,
  input  logic [WORD_W-1:0]  base_word,
  input  logic [WORD_W-1:0]  step_word,
  input  logic               ramp_en,
  input  logic               auto_repeat,
  input  logic               one_way,
  input  logic               single_step,
  input  logic               start_down,
  input  logic [CNT_W-1:0]   step_num,
  input  logic [DWELL_W-1:0] dwell_num,
  output logic [WORD_W-1:0]  word_q,
  output logic               dir_dn,
  output logic               busy,
  output logic               upd_q
);
  sw_state_t           state;
  logic [WORD_W-1:0]   start_q;
  logic                hop_pend;
  logic [CNT_W-1:0]    remain;
  logic [DWELL_W-1:0]  dwell_cnt;
  logic [CNT_W-1:0]    eff_n;

  sw_state_t           end_state;
  logic                end_dir;
  logic                end_hop;

  assign eff_n = (step_num == '0) ? CNT_W'(1) : step_num;

  // What happens once the last step of a sweep is taken
  always_comb begin
    if (auto_repeat) begin
      end_state = SW_DWELL;
      end_dir   = ~dir_dn;
      end_hop   = 1'b0;
    end else if (one_way) begin
      end_state = SW_HOLD;
      end_dir   = dir_dn;
      end_hop   = 1'b1;
    end else begin
      end_state = SW_HOLD;
      end_dir   = ~dir_dn;
      end_hop   = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= SW_OFF;
      word_q    <= '0;
      start_q   <= '0;
      dir_dn    <= 1'b0;
      hop_pend  <= 1'b0;
      remain    <= '0;
      dwell_cnt <= '0;
      upd_q     <= 1'b0;
    end else begin
      upd_q <= 1'b0;
      if (!ramp_en) begin
        state    <= SW_OFF;
        word_q   <= base_word;
        hop_pend <= 1'b0;
      end else begin
        case (state)
          SW_OFF: begin
            start_q  <= word_q;
            dir_dn   <= start_down;
            hop_pend <= 1'b0;
            if (auto_repeat) begin
              state  <= SW_RAMP;
              remain <= eff_n;
            end else begin
              state  <= SW_HOLD;
            end
          end
          SW_HOLD: begin
            if (trig) begin
              if (hop_pend) begin
                word_q   <= start_q;
                upd_q    <= 1'b1;
                hop_pend <= 1'b0;
              end else if (single_step) begin
                word_q <= step_word;
                upd_q  <= 1'b1;
                if (eff_n == CNT_W'(1)) begin
                  state     <= end_state;
                  dir_dn    <= end_dir;
                  hop_pend  <= end_hop;
                  dwell_cnt <= dwell_num;
                end else begin
                  state  <= SW_SSTEP;
                  remain <= eff_n - CNT_W'(1);
                end
              end else begin
                state  <= SW_RAMP;
                remain <= eff_n;
              end
            end
          end
          SW_RAMP: begin
            if (ref_tick) begin
              word_q <= step_word;
              upd_q  <= 1'b1;
              if (remain == CNT_W'(1)) begin
                state     <= end_state;
                dir_dn    <= end_dir;
                hop_pend  <= end_hop;
                dwell_cnt <= dwell_num;
              end else begin
                remain <= remain - CNT_W'(1);
              end
            end
          end
          SW_SSTEP: begin
            if (trig) begin
              word_q <= step_word;
              upd_q  <= 1'b1;
              if (remain == CNT_W'(1)) begin
                state     <= end_state;
                dir_dn    <= end_dir;
                hop_pend  <= end_hop;
                dwell_cnt <= dwell_num;
              end else begin
                remain <= remain - CNT_W'(1);
              end
            end
          end
          SW_DWELL: begin
            if (!auto_repeat) begin
              state <= SW_HOLD;
            end else if (ref_tick) begin
              if (dwell_cnt <= DWELL_W'(1)) begin
                state  <= SW_RAMP;
                remain <= eff_n;
              end else begin
                dwell_cnt <= dwell_cnt - DWELL_W'(1);
              end
            end
          end
          default: state <= SW_OFF;
        endcase
      end
    end
  end

  assign busy = (state == SW_RAMP) || (state == SW_SSTEP);

  AST_QUIET_WORD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (state != SW_OFF && $past(state) != SW_OFF && !upd_q) |-> $stable(word_q)); // R2

  AST_SWEEP_LEFT_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (remain != '0)); // R3

  AST_RAMP_NOT_CUT: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state) == SW_RAMP && $past(remain) > CNT_W'(1) && $past(ramp_en))
      |-> (state == SW_RAMP)); // R10

  AST_OFF_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(ramp_en) |-> !busy); // R11
endmodule

// File: rtl/fsweep_seq.sv
`timescale 1ns/1ps
module fsweep_seq #(
  parameter int INT_W   = 16,
  parameter int FRAC_W  = 24,
  parameter int CNT_W   = 16,
  parameter int DWELL_W = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ref_tick,
  input  logic [INT_W+FRAC_W-1:0]  base_word,
  input  logic                     ramp_en,
  input  logic                     auto_repeat,
  input  logic                     one_way,
  input  logic                     single_step,
  input  logic                     start_down,
  input  logic                     ext_sel,
  input  logic [FRAC_W-1:0]        step_val,
  input  logic [CNT_W-1:0]         step_num,
  input  logic [DWELL_W-1:0]       dwell_num,
  input  logic                     reg_trig,
  input  logic                     ext_trig,
  output logic [INT_W+FRAC_W-1:0]  freq_word,
  output logic                     busy,
  output logic                     word_upd
);
  localparam int WORD_W = INT_W + FRAC_W;

  logic              trig;
  logic              dir_dn;
  logic [WORD_W-1:0] step_word;
  logic [WORD_W-1:0] step_wide;

  fsweep_trig u_trig (
    .clk      (clk),
    .rst_n    (rst_n),
    .ext_sel  (ext_sel),
    .reg_trig (reg_trig),
    .ext_trig (ext_trig),
    .trig     (trig)
  );

  fsweep_step #(.WORD_W(WORD_W), .STEP_W(FRAC_W)) u_step (
    .cur  (freq_word),
    .step (step_val),
    .down (dir_dn),
    .nxt  (step_word)
  );

  fsweep_ctrl #(.WORD_W(WORD_W), .CNT_W(CNT_W), .DWELL_W(DWELL_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .ref_tick    (ref_tick),
    .trig        (trig),
    .base_word   (base_word),
    .step_word   (step_word),
    .ramp_en     (ramp_en),
    .auto_repeat (auto_repeat),
    .one_way     (one_way),
    .single_step (single_step),
    .start_down  (start_down),
    .step_num    (step_num),
    .dwell_num   (dwell_num),
    .word_q      (freq_word),
    .dir_dn      (dir_dn),
    .busy        (busy),
    .upd_q       (word_upd)
  );

  assign step_wide = WORD_W'(step_val);

  AST_STEP_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
    (word_upd && $past(busy)) |->
      (((freq_word - $past(freq_word)) == $past(step_wide)) ||
       (($past(freq_word) - freq_word) == $past(step_wide)))); // R2
endmodule

// File: tb/test_fsweep_seq.sv
`timescale 1ns/1ps
module test_fsweep_seq;
  localparam int W = 40;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ref_tick = 1'b0;
  logic [W-1:0]  base_word = '0;
  logic          ramp_en = 1'b0;
  logic          auto_repeat = 1'b0;
  logic          one_way = 1'b0;
  logic          single_step = 1'b0;
  logic          start_down = 1'b0;
  logic          ext_sel = 1'b0;
  logic [23:0]   step_val = 24'h20;
  logic [15:0]   step_num = 16'd3;
  logic [15:0]   dwell_num = 16'd0;
  logic          reg_trig = 1'b0;
  logic          ext_trig = 1'b0;
  logic [W-1:0]  freq_word;
  logic          busy;
  logic          word_upd;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  localparam logic [W-1:0] B1 = {16'd100, 24'hFFFFF0};
  localparam logic [W-1:0] B2 = {16'd100, 24'h000010};
  localparam logic [W-1:0] S  = 40'h20;

  fsweep_seq i_fsweep_seq (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .base_word(base_word),
    .ramp_en(ramp_en), .auto_repeat(auto_repeat), .one_way(one_way),
    .single_step(single_step), .start_down(start_down), .ext_sel(ext_sel),
    .step_val(step_val), .step_num(step_num), .dwell_num(dwell_num),
    .reg_trig(reg_trig), .ext_trig(ext_trig), .freq_word(freq_word),
    .busy(busy), .word_upd(word_upd)
  );

  always #2 clk = ~clk;

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tick();
    ref_tick = 1'b1;
    @(negedge clk);
    ref_tick = 1'b0;
  endtask

  task automatic rtrig();
    reg_trig = 1'b1;
    @(negedge clk);
    reg_trig = 1'b0;
  endtask

  task automatic arm(input logic [W-1:0] base, input logic ar, input logic ow,
                     input logic ss, input logic dn, input logic [15:0] n);
    ramp_en = 1'b0;
    base_word = base;
    auto_repeat = ar; one_way = ow; single_step = ss; start_down = dn;
    step_num = n;
    cyc(2);
    ramp_en = 1'b1;
    cyc(1);
  endtask

  task automatic t_reset();
    chk("R1 reset word", freq_word, 0);
    chk("R1 reset busy", busy, 0);
    chk("R1 reset upd", word_upd, 0);
    base_word = B1;
    cyc(1);
    chk("R1 tracks base", freq_word, B1);
    chk("R1 no upd while off", word_upd, 0);
  endtask

  task automatic t_two_way();
    arm(B1, 0, 0, 0, 0, 16'd3);
    rtrig();
    chk("R10 busy on trigger", busy, 1);
    chk("R3 no step before tick", freq_word, B1);
    tick();
    chk("R2 carry into integer", freq_word, B1 + S);
    chk("R2 upd on step", word_upd, 1);
    cyc(1);
    chk("R2 upd one cycle", word_upd, 0);
    rtrig();
    tick();
    tick();
    chk("R3 final word", freq_word, B1 + 3 * S);
    chk("R10 busy drops at last step", busy, 0);
    tick();
    chk("R5 holds at end", freq_word, B1 + 3 * S);
    rtrig();
    tick(); tick(); tick();
    chk("R5 reverse back to start", freq_word, B1);
    chk("R5 idle after return", busy, 0);
  endtask

  task automatic t_down();
    arm(B2, 0, 0, 0, 1, 16'd2);
    rtrig();
    tick();
    chk("R4 falling first with borrow", freq_word, B2 - S);
    tick();
    chk("R4 falling final", freq_word, B2 - 2 * S);
  endtask

  task automatic t_one_way();
    arm(B1, 0, 1, 0, 0, 16'd2);
    rtrig();
    tick(); tick();
    chk("R6 sweep end", freq_word, B1 + 2 * S);
    rtrig();
    chk("R6 hop to start", freq_word, B1);
    chk("R6 hop upd", word_upd, 1);
    chk("R6 hop not busy", busy, 0);
    tick();
    chk("R6 waits after hop", freq_word, B1);
    rtrig();
    tick(); tick();
    chk("R6 ramps same direction", freq_word, B1 + 2 * S);
  endtask

  task automatic t_single();
    arm(B1, 0, 1, 1, 0, 16'd3);
    rtrig();
    chk("R7 first step", freq_word, B1 + S);
    chk("R7 busy after first", busy, 1);
    tick();
    chk("R7 tick ignored", freq_word, B1 + S);
    rtrig();
    chk("R7 busy mid", busy, 1);
    rtrig();
    chk("R7 third step", freq_word, B1 + 3 * S);
    chk("R7 busy ends at Nth", busy, 0);
    rtrig();
    chk("R7 trigger N+1 hops", freq_word, B1);
    rtrig();
    chk("R7 trigger N+2 steps", freq_word, B1 + S);
    chk("R7 busy again", busy, 1);
  endtask

  task automatic t_auto();
    dwell_num = 16'd3;
    arm(B1, 1, 0, 0, 0, 16'd2);
    chk("R8 starts without trigger", busy, 1);
    tick(); tick();
    chk("R8 first sweep end", freq_word, B1 + 2 * S);
    chk("R8 not busy in dwell", busy, 0);
    tick(); tick(); tick();
    chk("R8 dwell holds word", freq_word, B1 + 2 * S);
    tick();
    chk("R8 reverse first step", freq_word, B1 + S);
    tick();
    chk("R8 reverse end", freq_word, B1);
    base_word = B2;
    cyc(2);
    chk("R11 base ignored while enabled", freq_word, B1);
    ramp_en = 1'b0;
    cyc(1);
    chk("R11 tracks after disable", freq_word, B2);
    chk("R11 busy low after disable", busy, 0);
    auto_repeat = 1'b0;
  endtask

  task automatic t_ext();
    ext_sel = 1'b1;
    arm(B1, 0, 0, 0, 0, 16'd1);
    rtrig();
    cyc(2);
    chk("R9 reg strobe ignored", busy, 0);
    ext_trig = 1'b1;
    cyc(4);
    chk("R9 ext edge triggers", busy, 1);
    tick();
    chk("R9 ext sweep step", freq_word, B1 + S);
    cyc(5);
    chk("R9 level is not a trigger", busy, 0);
    ext_trig = 1'b0;
    cyc(3);
    ext_trig = 1'b1;
    cyc(4);
    tick();
    chk("R9 second edge reverses", freq_word, B1);
    ext_sel = 1'b0;
    ext_trig = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog R1 got=hung exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    t_reset();
    t_two_way();
    t_down();
    t_one_way();
    t_single();
    t_auto();
    t_ext();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule